// File: doc/BRIEF.md
# Asynchronous Strobe Register Slave with Four Port Banks

This block lets a host processor with an asynchronous, strobe-driven bus read and write a set of registers that belong to four ports. The host's chip select and its read and write strobes pass through synchronisers into the system clock domain. A falling edge on a strobe, seen while chip select is low, starts one access. The address, port select, data, width select and byte enables are taken at that edge, so the host must hold them stable while the strobe is low.

A read answers with a READY handshake. A fixed number of clocks after the synchronised read edge, the addressed word appears on the data output and READY rises. Both stay as they are until the host releases the read strobe. READY has its own output enable, which is low whenever chip select is high, so that several slaves can share one READY wire.

Each port has two control registers. One is an interrupt status register, whose bits are set by event pulses from the port logic and cleared by writing 1. The other is an interrupt enable register. Each port's interrupt output is the OR of its status bits masked by its enables. The other low addresses of each port hold plain storage. Chip select may stay low for any number of back-to-back accesses.

Top module: `regbus_slave`

## Requirements
- R1: After reset, `ready`, `ready_oe`, `data_oe` and all `irq` bits are 0, and every port's status register (address 0) and enable register (address 1) read back as 0.
- R2: While `cs_n` is high, read and write strobes have no effect: no register changes and `ready` stays 0. `ready_oe` is 0 from the third clock after `cs_n` rises and 1 from the third clock after it falls.
- R3: A write stores the data into the addressed register of the port given by `port_sel`. Each (port, address) pair is independent of the others.
- R4: `ready` rises exactly 6 clocks after `rd_n` falls: 2 synchroniser stages, 1 edge-detect stage and 3 clocks of latency. From that point `data_out` holds the addressed word and `data_oe` is 1.
- R5: `ready`, `data_oe` and `data_out` hold steady while `rd_n` stays low. `ready` and `data_oe` return to 0 within 3 clocks of `rd_n` rising.
- R6: One assertion of `cs_n` low serves any number of consecutive read and write cycles, and each falling strobe edge starts a new access.
- R7: When `bus_wide` is 1, `byte_en[0]` enables a write to bits 7:0 and `byte_en[1]` enables a write to bits 15:8. A byte lane whose enable is 0 keeps its old value.
- R8: When `bus_wide` is 0, a write changes only bits 7:0, and only if `byte_en[0]` is 1. A read in this mode returns bits 15:8 as zero.
- R9: Address 0 is the status register, address 1 is the enable register, and addresses 2 to 15 are storage. Addresses 16 to 255 read as 0, and writes to them are ignored; they do not alias onto addresses 0 to 15.
- R10: A one-clock pulse on `evt_i[16*p + b]` sets bit b of port p's status register. `irq[p]` is 1 exactly when the status and enable registers of port p share a set bit.
- R11: Writing 1 to a status bit clears that bit. Status bits written with 0 are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Asynchronous chip select, active low |
| rd_n | input | 1 | Asynchronous read strobe, active low |
| wr_n | input | 1 | Asynchronous write strobe, active low |
| addr | input | 8 | Register address, sampled at the strobe edge |
| port_sel | input | 2 | Port bank select, sampled at the strobe edge |
| bus_wide | input | 1 | 1 selects 16-bit transfers, 0 selects 8-bit transfers |
| byte_en | input | 2 | Active-high byte-lane write enables |
| data_in | input | 16 | Write data (the inbound half of the data pads) |
| data_out | output | 16 | Read data (the outbound half of the data pads) |
| data_oe | output | 1 | Drive enable for the data pads |
| ready | output | 1 | Read data valid |
| ready_oe | output | 1 | Drive enable for the READY pad |
| evt_i | input | 64 | Status set pulses, 16 bits per port |
| irq | output | 4 | Interrupt request, one bit per port |

## Verification
The assertions check the READY handshake on every cycle. They check that READY rises exactly the configured latency after a qualified read edge, that it holds while the strobe stays low and falls once the strobe is released, and that the data held on the bus does not change while READY is high. They also check that the data drive never occurs without READY, that the READY drive follows chip select, and that the upper byte is zero in 8-bit reads. Whether the right word was stored and returned can only be shown by the bench's scenarios. These cover the port and address sweep, the lane and width combinations, the address range limit, strobes ignored while chip select is high, and the way status, enable and clear combine into each interrupt.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_WAIT,
    RD_HOLD
  } rd_state_t;
endpackage

// File: rtl/regbus_sync.sv
module regbus_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/regbus_ctrl.sv
module regbus_ctrl
  import regbus_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PS_W      = 2,
  parameter int DATA_W    = 16,
  parameter int READY_LAT = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_s,
  input  logic                   rd_s,
  input  logic                   wr_s,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [PS_W-1:0]        port_sel,
  input  logic                   bus_wide,
  input  logic [DATA_W/8-1:0]    byte_en,
  input  logic [DATA_W-1:0]      din,
  input  logic [DATA_W-1:0]      rdata,
  output logic [ADDR_W-1:0]      rd_addr,
  output logic [PS_W-1:0]        rd_port,
  output logic                   rd_wide,
  output logic                   wr_req,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [PS_W-1:0]        wr_port,
  output logic [DATA_W-1:0]      wr_data,
  output logic [DATA_W/8-1:0]    wr_lanes,
  output logic                   ready,
  output logic                   ready_oe,
  output logic                   data_oe,
  output logic [DATA_W-1:0]      dout
);
  localparam int NLANE = DATA_W / LANE_W;
  localparam int CNT_W = $clog2(READY_LAT + 1);

  rd_state_t           st;
  logic [CNT_W-1:0]    cnt;
  logic                rd_q, wr_q;
  logic                rd_fall, wr_fall;
  logic [NLANE-1:0]    lanes_eff;
  logic [DATA_W-1:0]   rdata_fmt;

  assign rd_fall = rd_q & ~rd_s & ~cs_s;
  assign wr_fall = wr_q & ~wr_s & ~cs_s;

  generate
    if (NLANE > 1) begin : g_multi
      assign lanes_eff = bus_wide ? byte_en : {{(NLANE-1){1'b0}}, byte_en[0]};
      assign rdata_fmt = rd_wide ? rdata : {{(DATA_W-LANE_W){1'b0}}, rdata[LANE_W-1:0]};
    end else begin : g_single
      assign lanes_eff = byte_en;
      assign rdata_fmt = rdata;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= 1'b1;
      wr_q     <= 1'b1;
      ready_oe <= 1'b0;
    end else begin
      rd_q     <= rd_s;
      wr_q     <= wr_s;
      ready_oe <= ~cs_s;
    end
  end

  // write capture: one-cycle request toward the register file
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_req   <= 1'b0;
      wr_addr  <= '0;
      wr_port  <= '0;
      wr_data  <= '0;
      wr_lanes <= '0;
    end else begin
      wr_req <= wr_fall;
      if (wr_fall) begin
        wr_addr  <= addr;
        wr_port  <= port_sel;
        wr_data  <= din;
        wr_lanes <= lanes_eff;
      end
    end
  end

  // read handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RD_IDLE;
      cnt     <= '0;
      rd_addr <= '0;
      rd_port <= '0;
      rd_wide <= 1'b0;
      ready   <= 1'b0;
      data_oe <= 1'b0;
      dout    <= '0;
    end else begin
      case (st)
        RD_IDLE: begin
          if (rd_fall) begin
            rd_addr <= addr;
            rd_port <= port_sel;
            rd_wide <= bus_wide;
            cnt     <= CNT_W'(READY_LAT - 1);
            st      <= RD_WAIT;
          end
        end
        RD_WAIT: begin
          if (rd_s | cs_s) begin
            st <= RD_IDLE;
          end else if (cnt == '0) begin
            ready   <= 1'b1;
            data_oe <= 1'b1;
            dout    <= rdata_fmt;
            st      <= RD_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RD_HOLD: begin
          if (rd_s | cs_s) begin
            ready   <= 1'b0;
            data_oe <= 1'b0;
            st      <= RD_IDLE;
          end
        end
        default: st <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile
  import regbus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PS_W   = 2,
  parameter int NPORT  = 4,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_req,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [PS_W-1:0]         wr_port,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [DATA_W/8-1:0]     wr_lanes,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [PS_W-1:0]         rd_port,
  input  logic [NPORT*DATA_W-1:0] evt,
  output logic [DATA_W-1:0]       rdata,
  output logic [NPORT-1:0]        irq
);
  localparam int NLANE  = DATA_W / LANE_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int MEM_AW = PS_W + IDX_W;
  localparam int MEM_N  = NPORT * DEPTH;

  logic [IDX_W-1:0]               w_idx, r_idx;
  logic                           w_in, r_in;
  logic                           wr_mem;
  logic [MEM_AW-1:0]              w_ma, r_ma;
  logic [DATA_W-1:0]              lane_mask;
  logic [NPORT-1:0][DATA_W-1:0]   stat, en, clr;
  logic [NPORT-1:0]               en_hit;
  logic [DATA_W-1:0]              ctl_q, mem_rd;
  logic                           r_in_q, r_ctl_q;

  assign w_idx  = wr_addr[IDX_W-1:0];
  assign r_idx  = rd_addr[IDX_W-1:0];
  assign w_in   = (wr_addr[ADDR_W-1:IDX_W] == '0);
  assign r_in   = (rd_addr[ADDR_W-1:IDX_W] == '0);
  assign wr_mem = wr_req & w_in & (w_idx > IDX_W'(1));
  assign w_ma   = {wr_port, w_idx};
  assign r_ma   = {rd_port, r_idx};

  always_comb begin
    for (int l = 0; l < NLANE; l++)
      lane_mask[l*LANE_W +: LANE_W] = {LANE_W{wr_lanes[l]}};
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      clr[p]    = (wr_req && w_in && w_idx == '0 && wr_port == PS_W'(p))
                  ? (wr_data & lane_mask) : '0;
      en_hit[p] = wr_req && w_in && w_idx == IDX_W'(1) && wr_port == PS_W'(p);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      en   <= '0;
      irq  <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        stat[p] <= (stat[p] & ~clr[p]) | evt[p*DATA_W +: DATA_W];
        if (en_hit[p]) en[p] <= (en[p] & ~lane_mask) | (wr_data & lane_mask);
        irq[p] <= |(stat[p] & en[p]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      r_in_q  <= 1'b0;
      r_ctl_q <= 1'b0;
    end else begin
      r_in_q  <= r_in;
      r_ctl_q <= (r_idx < IDX_W'(2));
      ctl_q   <= (r_idx == '0) ? stat[rd_port] : en[rd_port];
    end
  end

  genvar gl;
  generate
    for (gl = 0; gl < NLANE; gl++) begin : g_lane
      logic [LANE_W-1:0] mem [MEM_N];
      logic [LANE_W-1:0] q;
      always_ff @(posedge clk) begin
        if (wr_mem && wr_lanes[gl]) mem[w_ma] <= wr_data[gl*LANE_W +: LANE_W];
        q <= mem[r_ma];
      end
      assign mem_rd[gl*LANE_W +: LANE_W] = q;
    end
  endgenerate

  assign rdata = !r_in_q ? '0 : (r_ctl_q ? ctl_q : mem_rd);
endmodule

// File: rtl/regbus_slave.sv
module regbus_slave #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 8,
  parameter int NPORT       = 4,
  parameter int IDX_W       = 4,
  parameter int READY_LAT   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    rd_n,
  input  logic                    wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [$clog2(NPORT)-1:0] port_sel,
  input  logic                    bus_wide,
  input  logic [DATA_W/8-1:0]     byte_en,
  input  logic [DATA_W-1:0]       data_in,
  output logic [DATA_W-1:0]       data_out,
  output logic                    data_oe,
  output logic                    ready,
  output logic                    ready_oe,
  input  logic [NPORT*DATA_W-1:0] evt_i,
  output logic [NPORT-1:0]        irq
);
  localparam int PS_W  = $clog2(NPORT);
  localparam int NLANE = DATA_W / 8;

  logic                cs_sync, rd_sync, wr_sync;
  logic [ADDR_W-1:0]   rd_addr, wr_addr;
  logic [PS_W-1:0]     rd_port, wr_port;
  logic                rd_wide, wr_req;
  logic [DATA_W-1:0]   wr_data, rdata;
  logic [NLANE-1:0]    wr_lanes;

  regbus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cs_n, rd_n, wr_n}),
    .q   ({cs_sync, rd_sync, wr_sync})
  );

  regbus_ctrl #(
    .ADDR_W(ADDR_W), .PS_W(PS_W), .DATA_W(DATA_W), .READY_LAT(READY_LAT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_sync),
    .rd_s     (rd_sync),
    .wr_s     (wr_sync),
    .addr     (addr),
    .port_sel (port_sel),
    .bus_wide (bus_wide),
    .byte_en  (byte_en),
    .din      (data_in),
    .rdata    (rdata),
    .rd_addr  (rd_addr),
    .rd_port  (rd_port),
    .rd_wide  (rd_wide),
    .wr_req   (wr_req),
    .wr_addr  (wr_addr),
    .wr_port  (wr_port),
    .wr_data  (wr_data),
    .wr_lanes (wr_lanes),
    .ready    (ready),
    .ready_oe (ready_oe),
    .data_oe  (data_oe),
    .dout     (data_out)
  );

  regbus_regfile #(
    .ADDR_W(ADDR_W), .PS_W(PS_W), .NPORT(NPORT), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (wr_req),
    .wr_addr  (wr_addr),
    .wr_port  (wr_port),
    .wr_data  (wr_data),
    .wr_lanes (wr_lanes),
    .rd_addr  (rd_addr),
    .rd_port  (rd_port),
    .evt      (evt_i),
    .rdata    (rdata),
    .irq      (irq)
  );
endmodule

// File: rtl/regbus_slave_chk.sv
module regbus_slave_chk #(
  parameter int READY_LAT = 3,
  parameter int DATA_W    = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_s,
  input logic              rd_s,
  input logic              ready,
  input logic              ready_oe,
  input logic              data_oe,
  input logic [DATA_W-1:0] dout,
  input logic              cap_wide
);
  logic       rd_prev;
  logic [7:0] since_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev    <= 1'b1;
      since_edge <= 8'hFF;
    end else begin
      rd_prev <= rd_s;
      if (rd_prev && !rd_s && !cs_s) since_edge <= 8'd0;
      else if (since_edge != 8'hFF)  since_edge <= since_edge + 8'd1;
    end
  end

  // R4: READY rises exactly READY_LAT clocks after the qualified read edge
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> since_edge == 8'(READY_LAT));

  // R4: data drive only with READY and its enable
  p_oe_ready_r4: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (ready && ready_oe));

  // R5: READY held while the strobe stays low under chip select
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ready && !rd_s && !cs_s) |=> ready);

  // R5: released strobe drops READY
  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (ready && rd_s) |=> !ready);

  // R5: read data frozen during the handshake
  p_dout_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready)) |-> $stable(dout));

  // R2: READY drive off after chip select goes away
  p_cs_float_r2: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !ready_oe);

  // R8: narrow reads present zero on the upper byte
  p_narrow_r8: assert property (@(posedge clk) disable iff (rst)
    (data_oe && !cap_wide) |-> dout[DATA_W-1:8] == '0);
endmodule

bind regbus_slave regbus_slave_chk #(.READY_LAT(READY_LAT), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_s     (cs_sync),
  .rd_s     (rd_sync),
  .ready    (ready),
  .ready_oe (ready_oe),
  .data_oe  (data_oe),
  .dout     (data_out),
  .cap_wide (rd_wide)
);

// File: tb/regbus_slave_test.sv
`timescale 1ns/1ps
module regbus_slave_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  addr = '0;
  logic [1:0]  port_sel = '0;
  logic        bus_wide = 1'b1;
  logic [1:0]  byte_en = 2'b11;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic        data_oe, ready, ready_oe;
  logic [63:0] evt_i = '0;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;
  logic [15:0] model [4][16];

  always #4 clk = ~clk;

  regbus_slave uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .port_sel(port_sel), .bus_wide(bus_wide), .byte_en(byte_en),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .ready(ready),
    .ready_oe(ready_oe), .evt_i(evt_i), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      finish_run();
    end
  end

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                        input bit wide, input logic [1:0] be);
    logic [15:0] r = old;
    if (be[0]) r[7:0] = d[7:0];
    if (wide && be[1]) r[15:8] = d[15:8];
    return r;
  endfunction

  task automatic host_write(input int p, input int a, input logic [15:0] d,
                            input bit wide, input logic [1:0] be);
    @(negedge clk);
    addr = 8'(a); port_sel = 2'(p); data_in = d; bus_wide = wide; byte_en = be;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    repeat (6) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic host_read(input int p, input int a, input bit wide, input logic [15:0] exp,
                           input string tag);
    int lat;
    logic [15:0] v;
    @(negedge clk);
    addr = 8'(a); port_sel = 2'(p); bus_wide = wide;
    repeat (2) @(negedge clk);
    rd_n = 1'b0;
    lat = 0;
    while (!ready && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 6, "R4 latency", 32'(lat), 32'd6);
    v = data_out;
    check(v == exp, tag, {16'h0, v}, {16'h0, exp});
    check(data_oe == 1'b1, "R4 data_oe with ready", {31'h0, data_oe}, 32'd1);
    repeat (4) @(negedge clk);
    check(ready && data_oe && data_out == v, "R5 hold while strobe low",
          {14'h0, ready, data_oe, data_out}, {16'h3, v});
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!ready && !data_oe, "R5 release", {30'h0, ready, data_oe}, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(!ready && !ready_oe && !data_oe && irq == 4'h0, "R1 reset outputs",
          {25'h0, ready, ready_oe, data_oe, irq}, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    check(ready_oe == 1'b1, "R2 ready_oe under chip select", {31'h0, ready_oe}, 32'd1);

    for (int p = 0; p < 4; p++) begin
      host_read(p, 0, 1'b1, 16'h0000, "R1 status reset");
      host_read(p, 1, 1'b1, 16'h0000, "R1 enable reset");
    end

    // R3, R6: sweep of all ports and storage addresses within one chip select
    for (int p = 0; p < 4; p++)
      for (int a = 2; a < 16; a++) begin
        model[p][a] = 16'((p * 16'h1111) ^ (a * 16'h0a05) ^ 16'h5c3a);
        host_write(p, a, model[p][a], 1'b1, 2'b11);
      end
    for (int p = 0; p < 4; p++)
      for (int a = 2; a < 16; a++)
        host_read(p, a, 1'b1, model[p][a], "R3 R6 sweep readback");

    // R7, R8: byte lanes and width
    for (int p = 0; p < 4; p++) begin
      logic [15:0] e;
      e = model[p][7];
      for (int be = 0; be < 4; be++) begin
        logic [15:0] d;
        d = 16'(16'h1357 * (be + 1) + p);
        e = merge(e, d, 1'b1, 2'(be));
        host_write(p, 7, d, 1'b1, 2'(be));
        host_read(p, 7, 1'b1, e, "R7 wide lane write");
      end
      for (int be = 0; be < 4; be++) begin
        logic [15:0] d;
        d = 16'(16'hf0c3 ^ (be * 16'h0101) ^ p);
        e = merge(e, d, 1'b0, 2'(be));
        host_write(p, 7, d, 1'b0, 2'(be));
        host_read(p, 7, 1'b1, e, "R8 narrow write keeps upper byte");
        host_read(p, 7, 1'b0, {8'h00, e[7:0]}, "R8 narrow read upper zero");
      end
      model[p][7] = e;
    end

    // R9: out-of-range addresses
    host_write(0, 8'h12, 16'hdead, 1'b1, 2'b11);
    host_write(0, 8'hff, 16'hbeef, 1'b1, 2'b11);
    host_read(0, 2, 1'b1, model[0][2], "R9 no alias onto low range");
    host_read(0, 8'h12, 1'b1, 16'h0000, "R9 out of range reads zero");
    host_read(0, 8'hff, 1'b1, 16'h0000, "R9 out of range reads zero");

    // R2: strobes ignored while chip select high
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ready_oe == 1'b0, "R2 ready_oe floats", {31'h0, ready_oe}, 32'd0);
    addr = 8'd3; port_sel = 2'd1; data_in = ~model[1][3]; bus_wide = 1'b1; byte_en = 2'b11;
    repeat (2) @(negedge clk);
    wr_n = 1'b0;
    repeat (6) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_n = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (ready || data_oe) seen++;
      end
      check(seen == 0, "R2 no ready without chip select", 32'(seen), 32'd0);
    end
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    host_read(1, 3, 1'b1, model[1][3], "R2 ignored write left register");

    // R10, R11: interrupts
    for (int p = 0; p < 4; p++) begin
      logic [15:0] pat, enb, clrv;
      pat  = 16'(16'h8001 | (16'h0010 << p));
      enb  = 16'(16'h0010 << p);
      clrv = enb;
      @(negedge clk);
      evt_i = 64'(pat) << (16 * p);
      @(negedge clk);
      evt_i = '0;
      repeat (4) @(negedge clk);
      check(irq == 4'h0, "R10 masked status no irq", {28'h0, irq}, 32'd0);
      host_read(p, 0, 1'b1, pat, "R10 status set by event");
      host_write(p, 1, enb, 1'b1, 2'b11);
      check(irq == 4'(1 << p), "R10 irq per port", {28'h0, irq}, 32'(1 << p));
      host_write(p, 0, 16'h0000, 1'b1, 2'b11);
      host_read(p, 0, 1'b1, pat, "R11 zero write keeps status");
      host_write(p, 0, clrv, 1'b1, 2'b11);
      check(irq == 4'h0, "R11 cleared bit drops irq", {28'h0, irq}, 32'd0);
      host_read(p, 0, 1'b1, pat & ~clrv, "R11 write one clears");
      host_write(p, 0, 16'hffff, 1'b1, 2'b11);
    end

    finish_run();
  end
endmodule